// File: doc/BRIEF.md
# I2C Target Port with Status Flags

This block is the target (slave) side of an I2C link, clocked entirely by the system clock. It passes SCL and SDA through two-flop synchronizers and finds their edges. From those edges it picks out start, repeated-start and stop conditions. After a start it collects a 7-bit address, most significant bit first, followed by a direction bit. When the address equals the programmed own address, the block either acknowledges and moves into byte transfer, or refuses and leaves the bus alone until the next condition.

Software on the system side controls the block with level inputs: a module enable, a communication enable and an asynchronous-detect mode. Transmit bytes are supplied through a data bus and a write strobe. Received bytes come back on a data bus with a one-cycle valid pulse. Status is visible as busy, selected, direction, transmit-empty and asynchronous-detect flags. The asynchronous-detect flag also drives the bus-status interrupt. SDA is open-drain: the block only ever asserts an output enable that pulls the line low. The system clock must run at least eight times faster than the SCL rate.

Top module: `i2c_tgt`

## Requirements
- R1: A start condition (SDA falling while SCL is high) is recognised only when `enable` is 1. If `enable` is lowered while `busy` is 1, the change is ignored until after the stop, so the transfer in progress continues normally.
- R2: After a start, the first 8 SCL rising edges sample A6..A0 and then the direction bit. When the address equals `ownAddr` and `commEnable` is 1 (and `asyncDetEn` is 0), `sdaOe` is 1 during the ninth SCL clock (ACK).
- R3: When `commEnable` is 0, an own-address match gets no response: `sdaOe` stays 0 in the ninth clock (NAK), and `selected` stays 0.
- R4: `busy` becomes 1 on a recognised start and returns to 0 on a stop (SDA rising while SCL is high).
- R5: `selected` becomes 1 when an own-address match is acknowledged. It returns to 0 on a stop or a repeated start. Non-matching addresses never set it.
- R6: `dirRead` holds the direction bit of the acknowledged address: 0 means the master writes to this block, 1 means this block sends to the master.
- R7: With `asyncDetEn` at 1, an own-address match answers NAK, leaves `selected` at 0, and sets `asyncDet` and `busIrq`. A one-cycle pulse on `asyncClr` clears them.
- R8: In receive direction, each byte is shifted in MSB first and presented on `rxData` with a one-cycle `rxValid` pulse. The block answers ACK in the ninth clock of every byte.
- R9: In transmit direction, `txEmpty` rises when the address is acknowledged. It rises again each time the held byte is moved into the shifter, which happens at the SCL falling edge that ends the ninth clock. A `txWrite` clears it. Bytes are sent MSB first.
- R10: A `txWrite` always replaces the held transmit byte, even if the previous one was never sent.
- R11: In transmit direction, a NAK from the master (SDA high in the ninth clock) ends the transmission. SDA then stays released until the next start or stop, while `busy` remains 1.
- R12: `sdaOe` is 0 whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Module enable; allows start detection |
| commEnable | input | 1 | Allows an ACK to the own address |
| asyncDetEn | input | 1 | Asynchronous address-detect mode |
| asyncClr | input | 1 | Write-1 clear pulse for `asyncDet` |
| ownAddr | input | 7 | Own 7-bit target address |
| txData | input | 8 | Transmit byte to load |
| txWrite | input | 1 | Load strobe for `txData` |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sdaOe | output | 1 | Pull SDA low when 1 |
| rxData | output | 8 | Last received byte |
| rxValid | output | 1 | One-cycle pulse when `rxData` updates |
| busy | output | 1 | Bus busy flag |
| selected | output | 1 | Addressed-and-acknowledged flag |
| dirRead | output | 1 | Latched direction bit |
| txEmpty | output | 1 | Transmit byte requested |
| asyncDet | output | 1 | Asynchronous own-address detect flag |
| busIrq | output | 1 | Bus-status interrupt |

## Verification
A wrong control state shows up on `sdaOe` within one SCL clock. It appears as an ACK where a NAK is due, as a driven bit after a master NAK, or as a shifted or missing data bit. The master model reads each of these on the very next SCL high phase. Flag errors appear on `busy`, `selected` and `txEmpty` a few system clocks after the synchronized edge that should have moved them. A stale shifter or transmit buffer appears as a wrong byte on the next `rxData` update or on the next transmit byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startDet;
    logic stopDet;
    logic sdaLvl;
  } busEv_t;

  typedef struct packed {
    logic shiftIn;
    logic captureRx;
    logic loadTx;
    logic shiftTx;
  } dpCmd_t;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ADDR_DONE, S_ACK_OUT, S_RX, S_RX_DONE,
    S_TX, S_TX_DONE, S_TX_MACK, S_WAIT
  } tgtState_t;

endpackage

// File: rtl/i2c_tgt_datapath.sv
module i2c_tgt_datapath
  import i2c_tgt_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic [DATA_W-1:0] txData,
  input  logic              txWrite,
  input  dpCmd_t            cmd,
  output busEv_t            ev,
  output logic              addrMatch,
  output logic              txBit,
  output logic [DATA_W-1:0] rxData
);

  localparam int SYNC_W = 3;

  logic [SYNC_W-1:0] sclPipe, sdaPipe;
  logic [DATA_W-1:0] shiftReg, txBuf;
  logic sclNow, sclOld, sdaNow, sdaOld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[SYNC_W-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_W-2:0], sdaIn};
    end
  end

  assign sclNow = sclPipe[SYNC_W-2];
  assign sclOld = sclPipe[SYNC_W-1];
  assign sdaNow = sdaPipe[SYNC_W-2];
  assign sdaOld = sdaPipe[SYNC_W-1];

  assign ev.sclRise  = sclNow & ~sclOld;
  assign ev.sclFall  = ~sclNow & sclOld;
  assign ev.startDet = sclNow & sclOld & sdaOld & ~sdaNow;
  assign ev.stopDet  = sclNow & sclOld & ~sdaOld & sdaNow;
  assign ev.sdaLvl   = sdaNow;

  assign addrMatch = (shiftReg[ADDR_W-1:0] == ownAddr);
  assign txBit     = shiftReg[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      txBuf    <= '0;
      rxData   <= '0;
    end else begin
      if (txWrite) txBuf <= txData;
      if (cmd.loadTx)       shiftReg <= txBuf;
      else if (cmd.shiftTx) shiftReg <= {shiftReg[DATA_W-2:0], 1'b1};
      else if (cmd.shiftIn) shiftReg <= {shiftReg[DATA_W-2:0], sdaNow};
      if (cmd.captureRx) rxData <= {shiftReg[DATA_W-2:0], sdaNow};
    end
  end

  p_txbuf_replace_r10: assert property (@(posedge clk) disable iff (!rstN)
    txWrite |=> (txBuf == $past(txData)));

  p_load_shifter_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.loadTx && !txWrite) |=> (shiftReg == $past(txBuf)));

endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   enable,
  input  logic   commEnable,
  input  logic   asyncDetEn,
  input  logic   asyncClr,
  input  logic   txWrite,
  input  busEv_t ev,
  input  logic   addrMatch,
  output dpCmd_t cmd,
  output logic   ackDrive,
  output logic   txDrive,
  output logic   rxValid,
  output logic   busy,
  output logic   selected,
  output logic   dirRead,
  output logic   txEmpty,
  output logic   asyncDet
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  tgtState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic enLatched;

  always_comb begin
    cmd.shiftIn   = ev.sclRise && (state == S_ADDR || state == S_RX);
    cmd.captureRx = ev.sclRise && state == S_RX && bitCnt == LAST;
    cmd.loadTx    = ev.sclFall && state == S_ACK_OUT && dirRead;
    cmd.shiftTx   = ev.sclFall && state == S_TX;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      bitCnt    <= '0;
      enLatched <= 1'b0;
      ackDrive  <= 1'b0;
      txDrive   <= 1'b0;
      rxValid   <= 1'b0;
      busy      <= 1'b0;
      selected  <= 1'b0;
      dirRead   <= 1'b0;
      txEmpty   <= 1'b0;
      asyncDet  <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (!busy) enLatched <= enable;
      if (asyncClr) asyncDet <= 1'b0;
      if (txWrite) txEmpty <= 1'b0;
      if (ev.stopDet && busy) begin
        state    <= S_IDLE;
        busy     <= 1'b0;
        selected <= 1'b0;
        ackDrive <= 1'b0;
        txDrive  <= 1'b0;
        txEmpty  <= 1'b0;
      end else if (ev.startDet && (enLatched || busy)) begin
        state    <= S_ADDR;
        bitCnt   <= '0;
        busy     <= 1'b1;
        selected <= 1'b0;
        ackDrive <= 1'b0;
        txDrive  <= 1'b0;
        txEmpty  <= 1'b0;
      end else begin
        unique case (state)
          S_ADDR: if (ev.sclRise) begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == LAST) begin
              if (addrMatch && asyncDetEn) begin
                asyncDet <= 1'b1;
                state    <= S_WAIT;
              end else if (addrMatch && commEnable) begin
                selected <= 1'b1;
                dirRead  <= ev.sdaLvl;
                if (ev.sdaLvl) txEmpty <= 1'b1;
                state    <= S_ADDR_DONE;
              end else begin
                state <= S_WAIT;
              end
            end
          end
          S_ADDR_DONE, S_RX_DONE: if (ev.sclFall) begin
            ackDrive <= 1'b1;
            state    <= S_ACK_OUT;
          end
          S_ACK_OUT: if (ev.sclFall) begin
            ackDrive <= 1'b0;
            bitCnt   <= '0;
            if (dirRead) begin
              txDrive <= 1'b1;
              txEmpty <= 1'b1;
              state   <= S_TX;
            end else begin
              state <= S_RX;
            end
          end
          S_RX: if (ev.sclRise) begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == LAST) begin
              rxValid <= 1'b1;
              state   <= S_RX_DONE;
            end
          end
          S_TX: if (ev.sclRise) begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == LAST) state <= S_TX_DONE;
          end
          S_TX_DONE: if (ev.sclFall) begin
            txDrive <= 1'b0;
            state   <= S_TX_MACK;
          end
          S_TX_MACK: if (ev.sclRise) begin
            state <= ev.sdaLvl ? S_WAIT : S_ACK_OUT;
          end
          default: ;
        endcase
      end
    end
  end

  p_busy_from_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(ev.startDet));

  p_stop_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ev.stopDet && busy) |=> (!busy && !selected));

  p_sel_within_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    selected |-> busy);

  p_async_refuses_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(asyncDet) |-> (!selected && !ackDrive));

  p_rx_only_writes_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> !dirRead);

endmodule

// File: rtl/i2c_tgt.sv
module i2c_tgt
  import i2c_tgt_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              commEnable,
  input  logic              asyncDetEn,
  input  logic              asyncClr,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic [DATA_W-1:0] txData,
  input  logic              txWrite,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              busy,
  output logic              selected,
  output logic              dirRead,
  output logic              txEmpty,
  output logic              asyncDet,
  output logic              busIrq
);

  busEv_t ev;
  dpCmd_t cmd;
  logic addrMatch, txBit, ackDrive, txDrive;

  i2c_tgt_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .ownAddr(ownAddr), .txData(txData), .txWrite(txWrite), .cmd(cmd),
    .ev(ev), .addrMatch(addrMatch), .txBit(txBit), .rxData(rxData)
  );

  i2c_tgt_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .commEnable(commEnable),
    .asyncDetEn(asyncDetEn), .asyncClr(asyncClr), .txWrite(txWrite),
    .ev(ev), .addrMatch(addrMatch), .cmd(cmd), .ackDrive(ackDrive),
    .txDrive(txDrive), .rxValid(rxValid), .busy(busy),
    .selected(selected), .dirRead(dirRead), .txEmpty(txEmpty),
    .asyncDet(asyncDet)
  );

  assign sdaOe  = ackDrive | (txDrive & ~txBit);
  assign busIrq = asyncDet;

  p_released_when_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sdaOe);

endmodule

// File: tb/i2c_tgt_bench.sv
module i2c_tgt_bench;

  localparam int HALF = 10;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, commEnable = 1'b0, asyncDetEn = 1'b0, asyncClr = 1'b0;
  logic [6:0] ownAddr = OWN;
  logic [7:0] txData = '0;
  logic txWrite = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic sdaOe, rxValid, busy, selected, dirRead, txEmpty, asyncDet, busIrq;
  logic [7:0] rxData;
  logic sdaBus;
  int vectors = 0, fails = 0;
  bit done = 0;

  assign sdaBus = mSda & ~sdaOe;

  always #2 clk = ~clk;

  i2c_tgt u_i2c_tgt (
    .clk(clk), .rstN(rstN), .enable(enable), .commEnable(commEnable),
    .asyncDetEn(asyncDetEn), .asyncClr(asyncClr), .ownAddr(ownAddr),
    .txData(txData), .txWrite(txWrite), .sclIn(mScl), .sdaIn(sdaBus),
    .sdaOe(sdaOe), .rxData(rxData), .rxValid(rxValid), .busy(busy),
    .selected(selected), .dirRead(dirRead), .txEmpty(txEmpty),
    .asyncDet(asyncDet), .busIrq(busIrq)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bitXfer(input logic b, output logic r);
    mSda = b;
    waitClk(HALF);
    mScl = 1'b1;
    waitClk(HALF);
    r = sdaBus;
    mScl = 1'b0;
    waitClk(4);
  endtask

  task automatic startCond();
    mSda = 1'b1; waitClk(4);
    mScl = 1'b1; waitClk(HALF);
    mSda = 1'b0; waitClk(HALF);
    mScl = 1'b0; waitClk(4);
  endtask

  task automatic stopCond();
    mSda = 1'b0; waitClk(4);
    mScl = 1'b1; waitClk(HALF);
    mSda = 1'b1; waitClk(HALF);
  endtask

  task automatic send8(input logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) bitXfer(d[i], r);
  endtask

  task automatic ackBit(output logic a);
    bitXfer(1'b1, a);
  endtask

  task automatic readByte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bitXfer(1'b1, r);
      d[i] = r;
    end
    bitXfer(mack, r);
  endtask

  task automatic pushTx(input logic [7:0] d);
    txData = d; txWrite = 1'b1;
    waitClk(1);
    txWrite = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    waitClk(5);
    rstN = 1'b1;
    waitClk(3);
    check("R12 reset sdaOe", sdaOe, 0);
    check("R4 reset busy", busy, 0);
    check("R5 reset selected", selected, 0);
    check("R9 reset txEmpty", txEmpty, 0);
    check("R7 reset asyncDet", asyncDet, 0);

    // R1: start ignored while disabled
    startCond();
    check("R1 start ignored when disabled", busy, 0);
    send8({OWN, 1'b0}); ackBit(a);
    check("R1 no ACK when disabled", a, 1);
    stopCond();
    enable = 1'b1; waitClk(3);

    // R3: communication disabled -> NAK
    startCond();
    check("R4 busy after start", busy, 1);
    send8({OWN, 1'b0});
    check("R3 not selected with comm off", selected, 0);
    ackBit(a);
    check("R3 NAK with comm off", a, 1);
    stopCond();
    check("R4 busy cleared by stop", busy, 0);

    // R2/R5: sweep all addresses
    commEnable = 1'b1;
    for (int ad = 0; ad < 128; ad++) begin
      startCond();
      send8({ad[6:0], 1'b0});
      ackBit(a);
      check("R2 address sweep ack", a, (ad == OWN) ? 0 : 1);
      check("R5 address sweep selected", selected, (ad == OWN) ? 1 : 0);
      stopCond();
      check("R5 stop clears selected", selected, 0);
    end

    // R8: receive bytes; R1 enable drop mid-transfer ignored
    startCond();
    send8({OWN, 1'b0}); ackBit(a);
    check("R2 write address ack", a, 0);
    check("R6 direction write", dirRead, 0);
    enable = 1'b0;
    for (int k = 0; k < 5; k++) begin
      d = 8'(k * 8'h5B + 8'h17);
      send8(d); ackBit(a);
      check("R8 data ACK", a, 0);
      check("R8 rxData", rxData, d);
    end
    // repeated start clears selected
    startCond();
    check("R5 repeated start clears selected", selected, 0);
    check("R4 busy held across repeated start", busy, 1);
    stopCond();
    waitClk(3);
    startCond();
    check("R1 enable drop applied after stop", busy, 0);
    stopCond();
    enable = 1'b1; waitClk(3);

    // R9/R10/R11: transmit
    startCond();
    send8({OWN, 1'b1});
    check("R5 selected on read address", selected, 1);
    check("R6 direction read", dirRead, 1);
    check("R9 txEmpty on select", txEmpty, 1);
    pushTx(8'hC3);
    check("R9 txEmpty cleared by write", txEmpty, 0);
    ackBit(a);
    check("R2 read address ack", a, 0);
    check("R9 txEmpty after load", txEmpty, 1);
    pushTx(8'h5A);
    pushTx(8'h96);
    readByte(1'b0, d);
    check("R9 first byte MSB first", d, 8'hC3);
    readByte(1'b1, d);
    check("R10 overwritten byte sent", d, 8'h96);
    check("R11 released after master NAK", sdaOe, 0);
    readByte(1'b1, d);
    check("R11 no drive after NAK", d, 8'hFF);
    check("R11 busy held after NAK", busy, 1);
    stopCond();
    check("R12 released after stop", sdaOe, 0);

    // R7: asynchronous detect
    asyncDetEn = 1'b1;
    startCond();
    send8({OWN, 1'b0}); ackBit(a);
    check("R7 NAK in async mode", a, 1);
    check("R7 not selected", selected, 0);
    check("R7 flag set", asyncDet, 1);
    check("R7 interrupt", busIrq, 1);
    stopCond();
    check("R7 flag survives stop", asyncDet, 1);
    asyncClr = 1'b1; waitClk(1); asyncClr = 1'b0; waitClk(1);
    check("R7 flag cleared", asyncDet, 0);
    check("R7 interrupt cleared", busIrq, 0);
    asyncDetEn = 1'b0;
    startCond();
    send8({OWN, 1'b0}); ackBit(a);
    check("R7 retry acknowledged", a, 0);
    stopCond();

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule